// File: doc/BRIEF.md
# Word-Parallel Programmable PRBS Source

This block produces a pseudo-random binary sequence from a linear feedback shift register of `N` stages, emitting a 20-bit slice of the serial stream on every clock where the advance input is set. The feedback polynomial is a run-time input vector, so one build of the block can follow any polynomial that fits in `N` stages, whether or not it is maximal-length. Each advance is the equivalent of twenty single-bit register shifts, unrolled as a chain of next-state expressions inside one clock.

A build-time parameter picks one of two register structures. In the external-XOR form, the taps are combined into one feedback bit that enters the low end. In the internal-XOR form, the bit leaving the top is folded back into every tapped stage. Both forms use the same polynomial encoding. A run-time flag turns on a guard that reseeds the register whenever it would fall into the all-zero state.

Post-processing such as output inversion or zero-run suppression is left to wrapper logic. Test-pattern wrappers tie `poly_i` to a constant and invert `data_o` where their pattern needs it.

Top module: `prbs_par_gen`

## Requirements
- R1: Reset is synchronous and active high. A clock edge with `rst_i` high loads every stage with 1 and clears `data_o` to zero, whatever `adv_i` is. The first advance after reset therefore starts from the all-ones seed.
- R2: On a clock edge where `adv_i` is low (and `rst_i` is low), both the register and `data_o` keep their values.
- R3: Bit k of `poly_i` set means the term x^(N-k) is present. Bit 0 stands for x^N, so x^31+x^28 in 31 stages is 0x00000009, and x^32+x^31+x^30+x^10 in 32 stages is 0x00400007.
- R4: External-XOR structure (STYLE = LFSR_EXT). One serial step emits stage N-1. It then shifts the register up by one place and fills stage 0 with the XOR, over all k, of `poly_i[k]` AND stage N-1-k.
- R5: Internal-XOR structure (STYLE = LFSR_INT). One serial step emits stage N-1 as the bit o and shifts the register up, with 0 into stage 0. If o is 1, it then XORs stage 0 with `poly_i[0]` and stage i with `poly_i[N-i]` for i = 1..N-1.
- R6: Each clock edge with `adv_i` high performs 20 serial steps. The 20 emitted bits appear on `data_o` after that edge, with `data_o[19]` the earliest bit and `data_o[0]` the latest.
- R7: With `maxlen_i` high on an advancing edge, if the register after the 20 steps would be all zero, it is loaded with all ones instead. The word for that edge is unchanged.
- R8: With `maxlen_i` low, an all-zero register stays all zero on every advance and emits all-zero words.
- R9: With a maximal-length polynomial, the serial stream repeats every 2^N-1 bits. The word on advance t+2^N-1 equals the word on advance t.
- R10: A new `poly_i` value takes effect on the next advancing edge without a reset. The register keeps its present contents across the change.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Pattern clock, rising edge |
| rst_i | input | 1 | Synchronous reset, active high |
| adv_i | input | 1 | Advance the sequence by one 20-bit word |
| poly_i | input | N | Feedback polynomial; bit k is the x^(N-k) term |
| maxlen_i | input | 1 | Enables reseeding when the register would reach all zero |
| data_o | output | 20 | Latest 20 sequence bits, earliest bit in the MSB |

## Verification
The hardest states to reach from the ports are the all-zero register and the wrap of a maximal-length sequence. The all-zero state cannot come from the all-ones seed under any usable polynomial. The bench forces it by switching `poly_i` to zero at run time with `maxlen_i` low: both structures then shift in only zeros, and after two advances the register has been flushed. The bench checks that zeros persist, then raises `maxlen_i` and checks that the next word is zero and the one after it is all ones. The wrap of the sequence is reached only in small builds of five stages, where 31 advances cover one period.

// File: rtl/prbs_par_pkg.sv
package prbs_par_pkg;

    // Register structure selected at build time
    typedef enum logic {
        LFSR_EXT = 1'b0,   // taps summed into one feedback bit
        LFSR_INT = 1'b1    // leaving bit folded into each tapped stage
    } lfsr_style_e;

    // Serial bits produced per advance
    localparam int unsigned PRBS_WORD_W = 20;

endpackage

// File: rtl/prbs_coef_map.sv
// Turns the polynomial encoding into the per-stage coefficient vector
// used by the single-step logic of the chosen structure.
module prbs_coef_map
    import prbs_par_pkg::*;
#(
    parameter int unsigned N     = 23,
    parameter lfsr_style_e STYLE = LFSR_EXT
) (
    input  logic [N-1:0] poly_i,
    output logic [N-1:0] coef_o
);

    always_comb begin
        coef_o = '0;
        if (STYLE == LFSR_EXT) begin
            // stage j contributes when the term x^(j+1) is present
            for (int j = 0; j < N; j++) begin
                coef_o[j] = poly_i[N-1-j];
            end
        end else begin
            // stage i receives the leaving bit when x^i is present
            coef_o[0] = poly_i[0];
            for (int i = 1; i < N; i++) begin
                coef_o[i] = poly_i[N-i];
            end
        end
    end

endmodule

// File: rtl/prbs_step_ext.sv
// One serial shift of the external-XOR register.
module prbs_step_ext #(
    parameter int unsigned N = 23
) (
    input  logic [N-1:0] state_i,
    input  logic [N-1:0] coef_i,
    output logic [N-1:0] state_o,
    output logic         bit_o
);

    logic fb;

    always_comb begin
        fb      = ^(coef_i & state_i);
        bit_o   = state_i[N-1];
        state_o = {state_i[N-2:0], fb};
    end

endmodule

// File: rtl/prbs_step_int.sv
// One serial shift of the internal-XOR register.
module prbs_step_int #(
    parameter int unsigned N = 23
) (
    input  logic [N-1:0] state_i,
    input  logic [N-1:0] coef_i,
    output logic [N-1:0] state_o,
    output logic         bit_o
);

    logic lead;

    always_comb begin
        lead    = state_i[N-1];
        bit_o   = lead;
        state_o = {state_i[N-2:0], 1'b0} ^ ({N{lead}} & coef_i);
    end

endmodule

// File: rtl/prbs_cascade.sv
// Chains W single-step stages so that one clock covers W serial shifts.
module prbs_cascade
    import prbs_par_pkg::*;
#(
    parameter int unsigned N     = 23,
    parameter int unsigned W     = PRBS_WORD_W,
    parameter lfsr_style_e STYLE = LFSR_EXT
) (
    input  logic [N-1:0] state_i,
    input  logic [N-1:0] coef_i,
    output logic [N-1:0] state_o,
    output logic [W-1:0] word_o
);

    logic [N-1:0] chain [0:W];

    assign chain[0] = state_i;
    assign state_o  = chain[W];

    for (genvar g = 0; g < W; g++) begin : g_step
        if (STYLE == LFSR_EXT) begin : g_ext
            prbs_step_ext #(.N(N)) u_step (
                .state_i (chain[g]),
                .coef_i  (coef_i),
                .state_o (chain[g+1]),
                .bit_o   (word_o[W-1-g])
            );
        end else begin : g_int
            prbs_step_int #(.N(N)) u_step (
                .state_i (chain[g]),
                .coef_i  (coef_i),
                .state_o (chain[g+1]),
                .bit_o   (word_o[W-1-g])
            );
        end
    end

endmodule

// File: rtl/prbs_par_gen.sv
// Word-parallel PRBS source with a run-time polynomial.
module prbs_par_gen
    import prbs_par_pkg::*;
#(
    parameter int unsigned N     = 23,
    parameter int unsigned W     = PRBS_WORD_W,
    parameter lfsr_style_e STYLE = LFSR_EXT
) (
    input  logic         clk_i,
    input  logic         rst_i,
    input  logic         adv_i,
    input  logic [N-1:0] poly_i,
    input  logic         maxlen_i,
    output logic [W-1:0] data_o
);

    localparam logic [N-1:0] SEED = {N{1'b1}};

    typedef struct packed {
        logic [N-1:0] state;
        logic [W-1:0] word;
    } gen_s;

    gen_s         cur_q;
    gen_s         nxt_d;
    logic [N-1:0] coef;
    logic [N-1:0] casc_state;
    logic [W-1:0] casc_word;
    logic [N-1:0] state_q;

    prbs_coef_map #(.N(N), .STYLE(STYLE)) u_coef (
        .poly_i (poly_i),
        .coef_o (coef)
    );

    prbs_cascade #(.N(N), .W(W), .STYLE(STYLE)) u_casc (
        .state_i (cur_q.state),
        .coef_i  (coef),
        .state_o (casc_state),
        .word_o  (casc_word)
    );

    always_comb begin
        nxt_d = cur_q;
        if (adv_i) begin
            nxt_d.word  = casc_word;
            nxt_d.state = casc_state;
            if (maxlen_i && (casc_state == '0)) begin
                nxt_d.state = SEED;
            end
        end
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            cur_q.state <= SEED;
            cur_q.word  <= '0;
        end else begin
            cur_q <= nxt_d;
        end
    end

    assign state_q = cur_q.state;
    assign data_o  = cur_q.word;

endmodule

// File: rtl/prbs_par_gen_chk.sv
module prbs_par_gen_chk #(
    parameter int unsigned N = 23,
    parameter int unsigned W = 20
) (
    input logic         clk_i,
    input logic         rst_i,
    input logic         adv_i,
    input logic         maxlen_i,
    input logic [N-1:0] state_q,
    input logic [W-1:0] data_o
);

    // R1: the cycle after a reset edge shows the seed and a cleared word
    assert_reset_seed_R1: assert property (@(posedge clk_i) disable iff (rst_i)
        $past(rst_i) |-> (state_q == {N{1'b1}}) && (data_o == '0));

    // R2: no advance, no movement
    assert_hold_R2: assert property (@(posedge clk_i) disable iff (rst_i)
        !adv_i |=> $stable(state_q) && $stable(data_o));

    // R7: the guard never leaves the register empty
    assert_lockup_guard_R7: assert property (@(posedge clk_i) disable iff (rst_i)
        (adv_i && maxlen_i) |=> (state_q != '0));

    // R8: without the guard an empty register stays empty and emits zeros
    assert_zero_sticks_R8: assert property (@(posedge clk_i) disable iff (rst_i)
        (adv_i && !maxlen_i && (state_q == '0)) |=> (state_q == '0) && (data_o == '0));

endmodule

bind prbs_par_gen prbs_par_gen_chk #(.N(N), .W(W)) u_chk (
    .clk_i    (clk_i),
    .rst_i    (rst_i),
    .adv_i    (adv_i),
    .maxlen_i (maxlen_i),
    .state_q  (state_q),
    .data_o   (data_o)
);

// File: tb/prbs_par_gen_ref.sv
package prbs_ref_pkg;

    // Behavioural reference: 20 single-bit shifts on an n-stage register
    // held in the low bits of a 32-bit word.
    function automatic logic [31:0] ref_adv(
        input  logic [31:0] s_in,
        input  logic [31:0] p,
        input  int          n,
        input  bit          galois,
        input  bit          guard,
        output logic [19:0] w
    );
        logic [31:0] s;
        logic [31:0] mask;
        logic [31:0] t;
        logic        o;
        logic        fb;
        mask = (n == 32) ? 32'hFFFF_FFFF : ((32'h1 << n) - 32'h1);
        s    = s_in;
        w    = '0;
        for (int b = 0; b < 20; b++) begin
            o        = s[n-1];
            w[19-b]  = o;
            if (!galois) begin
                fb = 1'b0;
                for (int k = 0; k < n; k++) fb = fb ^ (p[k] & s[n-1-k]);
                s = ((s << 1) | {31'b0, fb}) & mask;
            end else begin
                t = (s << 1) & mask;
                if (o) begin
                    t[0] = t[0] ^ p[0];
                    for (int i = 1; i < n; i++) t[i] = t[i] ^ p[n-i];
                end
                s = t;
            end
        end
        if (guard && (s == 32'h0)) s = mask;
        return s;
    endfunction

endpackage

// Free-running comparison of one build against the reference, with a
// period check for small register lengths.
module prbs_lane #(
    parameter int          N      = 5,
    parameter bit          GALOIS = 1'b0,
    parameter logic [31:0] POLY   = 32'h5
) (
    input  logic clk,
    input  logic rst,
    input  logic run,
    output int   checks_o,
    output int   fails_o
);
    import prbs_ref_pkg::*;

    localparam prbs_par_pkg::lfsr_style_e STY =
        GALOIS ? prbs_par_pkg::LFSR_INT : prbs_par_pkg::LFSR_EXT;
    localparam logic [31:0] MASK = (N == 32) ? 32'hFFFF_FFFF : ((32'h1 << N) - 32'h1);
    localparam int          P    = (N <= 6) ? ((1 << N) - 1) : 0;

    logic        adv  = 1'b0;
    logic [19:0] dout;
    logic [31:0] m_s  = MASK;
    logic [19:0] m_w  = '0;
    logic        seen = 1'b0;
    logic [19:0] hist [128];
    int          hidx = 0;
    int          cnt  = 0;
    int          n_c  = 0;
    int          n_f  = 0;

    assign checks_o = n_c;
    assign fails_o  = n_f;

    prbs_par_gen #(.N(N), .W(20), .STYLE(STY)) u_dut (
        .clk_i    (clk),
        .rst_i    (rst),
        .adv_i    (adv),
        .poly_i   (POLY[N-1:0]),
        .maxlen_i (1'b1),
        .data_o   (dout)
    );

    always @(posedge clk) begin : mdl
        logic [19:0] w;
        logic [31:0] ns;
        seen <= 1'b0;
        if (rst) begin
            m_s <= MASK;
            m_w <= '0;
        end else if (adv) begin
            ns   = ref_adv(m_s, POLY, N, GALOIS, 1'b1, w);
            m_s  <= ns;
            m_w  <= w;
            seen <= 1'b1;
        end
    end

    always @(negedge clk) begin
        if (run && !rst) begin
            n_c++;
            if (dout !== m_w) begin
                n_f++;
                $display("FAIL R3 R4 R5 lane N=%0d galois=%0d: actual %05h expected %05h",
                         N, GALOIS, dout, m_w);
            end
            if ((P != 0) && seen && (hidx < 128)) begin
                hist[hidx] = dout;
                if (hidx >= P) begin
                    n_c++;
                    if (hist[hidx] !== hist[hidx-P]) begin
                        n_f++;
                        $display("FAIL R9 period N=%0d galois=%0d word %0d: actual %05h expected %05h",
                                 N, GALOIS, hidx, hist[hidx], hist[hidx-P]);
                    end
                end
                hidx++;
            end
        end
        adv <= run && ((cnt % 4) != 3);
        cnt++;
    end

endmodule

// File: tb/prbs_par_gen_bench.sv
module prbs_par_gen_bench;
    import prbs_ref_pkg::*;

    localparam int CLK_PERIOD = 10;
    localparam int NB         = 23;
    localparam int NLANE      = 10;
    localparam int LANE_N [5] = '{20, 29, 31, 32, 5};
    localparam logic [31:0] LANE_P [5] =
        '{32'h0000_0009, 32'h0000_0005, 32'h0000_0009, 32'h0040_0007, 32'h0000_0005};

    logic          clk      = 1'b0;
    logic          rst      = 1'b1;
    logic          lane_rst = 1'b1;
    logic          run      = 1'b0;
    logic          adv      = 1'b0;
    logic          maxlen   = 1'b1;
    logic [NB-1:0] poly     = 23'h000021;
    logic [19:0]   d_ext;
    logic [19:0]   d_int;
    logic [31:0]   m1_s     = 32'h007F_FFFF;
    logic [31:0]   m2_s     = 32'h007F_FFFF;
    logic [19:0]   m1_w     = '0;
    logic [19:0]   m2_w     = '0;
    string         tag      = "R1";
    int            n_chk    = 0;
    int            n_fail   = 0;
    bit            done     = 1'b0;
    int            lane_chk  [NLANE];
    int            lane_fail [NLANE];
    logic [19:0]   hold_e;
    logic [19:0]   hold_i;

    always #(CLK_PERIOD/2) clk = ~clk;

    prbs_par_gen #(.N(NB), .W(20), .STYLE(prbs_par_pkg::LFSR_EXT)) u_prbs_par_gen (
        .clk_i (clk), .rst_i (rst), .adv_i (adv),
        .poly_i (poly), .maxlen_i (maxlen), .data_o (d_ext)
    );

    prbs_par_gen #(.N(NB), .W(20), .STYLE(prbs_par_pkg::LFSR_INT)) u_prbs_par_gen_int (
        .clk_i (clk), .rst_i (rst), .adv_i (adv),
        .poly_i (poly), .maxlen_i (maxlen), .data_o (d_int)
    );

    for (genvar li = 0; li < 5; li++) begin : g_len
        for (genvar si = 0; si < 2; si++) begin : g_sty
            prbs_lane #(.N(LANE_N[li]), .GALOIS(si[0]), .POLY(LANE_P[li])) u_lane (
                .clk (clk), .rst (lane_rst), .run (run),
                .checks_o (lane_chk[li*2+si]), .fails_o (lane_fail[li*2+si])
            );
        end
    end

    // reference model for the two main builds
    always @(posedge clk) begin : mdl
        logic [19:0] w;
        logic [31:0] ns;
        if (rst) begin
            m1_s <= 32'h007F_FFFF; m1_w <= '0;
            m2_s <= 32'h007F_FFFF; m2_w <= '0;
        end else if (adv) begin
            ns = ref_adv(m1_s, {9'b0, poly}, NB, 1'b0, maxlen, w);
            m1_s <= ns; m1_w <= w;
            ns = ref_adv(m2_s, {9'b0, poly}, NB, 1'b1, maxlen, w);
            m2_s <= ns; m2_w <= w;
        end
    end

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic tick(input bit a);
        @(negedge clk);
        check({tag, " R4 ext"}, {12'b0, d_ext}, {12'b0, m1_w});
        check({tag, " R5 int"}, {12'b0, d_int}, {12'b0, m2_w});
        adv = a;
    endtask

    initial begin
        // R1: reset, with advance requested during it
        repeat (3) tick(1'b0);
        tick(1'b1);
        tick(1'b1);
        check("R1 reset word ext", {12'b0, d_ext}, 32'h0);
        check("R1 reset word int", {12'b0, d_int}, 32'h0);
        rst = 1'b0; lane_rst = 1'b0; run = 1'b1; adv = 1'b1;
        tick(1'b1);
        check("R6 first word from seed", {12'b0, d_ext}, 32'hFFFFF);

        tag = "R6";
        for (int i = 0; i < 150; i++) tick((i % 5) != 2);

        // R2: hold
        tag = "R2";
        tick(1'b0);
        hold_e = d_ext; hold_i = d_int;
        for (int i = 0; i < 8; i++) begin
            tick(1'b0);
            check("R2 hold ext", {12'b0, d_ext}, {12'b0, hold_e});
            check("R2 hold int", {12'b0, d_int}, {12'b0, hold_i});
        end

        // R10: polynomial swapped at run time
        tag = "R10";
        poly = 23'h000003;
        for (int i = 0; i < 40; i++) tick((i % 3) != 0);

        // R8: flush to zero with the guard off
        tag = "R8";
        poly = '0; maxlen = 1'b0; adv = 1'b1;
        tick(1'b1);
        tick(1'b1);
        tick(1'b1);
        check("R8 zero word ext", {12'b0, d_ext}, 32'h0);
        check("R8 zero word int", {12'b0, d_int}, 32'h0);
        tick(1'b1);
        check("R8 zero persists ext", {12'b0, d_ext}, 32'h0);
        check("R8 zero persists int", {12'b0, d_int}, 32'h0);

        // R7: guard on, register reseeds
        tag = "R7";
        maxlen = 1'b1;
        tick(1'b1);
        check("R7 word from empty ext", {12'b0, d_ext}, 32'h0);
        check("R7 word from empty int", {12'b0, d_int}, 32'h0);
        tick(1'b1);
        check("R7 reseeded ext", {12'b0, d_ext}, 32'hFFFFF);
        check("R7 reseeded int", {12'b0, d_int}, 32'hFFFFF);

        tag = "R3";
        poly = 23'h000021;
        for (int i = 0; i < 60; i++) tick((i % 7) != 4);

        // R1: reset in mid-run with advance held high
        tag = "R1";
        rst = 1'b1; adv = 1'b1;
        tick(1'b1);
        tick(1'b1);
        check("R1 mid-run reset ext", {12'b0, d_ext}, 32'h0);
        check("R1 mid-run reset int", {12'b0, d_int}, 32'h0);
        rst = 1'b0;
        tick(1'b1);
        check("R1 seed after reset", {12'b0, d_ext}, 32'hFFFFF);

        run = 1'b0;
        repeat (4) tick(1'b0);
        for (int i = 0; i < NLANE; i++) begin
            n_chk  += lane_chk[i];
            n_fail += lane_fail[i];
        end
        if (!done) begin
            done = 1'b1;
            $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        #(CLK_PERIOD * 200000);
        if (!done) begin
            done = 1'b1;
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
            $finish;
        end
    end

endmodule